// File: doc/BRIEF.md
# Adjustable Vertical Blanking Window with Raw Luma Bypass

This block turns a per-line strobe and two nominal strobes, one for the start of vertical blanking and one for its end, into an adjusted blanking flag. Each edge of the flag can be moved by its own signed 8-bit line code. A code can delay an edge by up to 127 lines after its nominal strobe. It can also advance an edge by up to 128 lines ahead of the next nominal strobe. To advance an edge, the block counts lines from the previous nominal strobe and uses a field length given as an input. The flag is driven out directly, so that pin can carry vertical blanking.

The same flag gates a raw-sample bypass. When the bypass enable is set and the flag is high, the pixel output carries raw converter samples instead of the processed video stream. The raw bytes are labelled alternately as colour-difference and luma, and each is clipped to the studio coding range for its kind. The alternation restarts with a colour-difference byte on every line strobe. An accompanying output tells which kind of byte is on the pixel bus. The block assumes that nominal strobes coincide with line strobes and that a field is longer than 128 lines.

Top module: `vblank_luma_bypass`

## Requirements
- R1: While rst_n is low at a clock edge, vblk, pix_out and pix_luma are all 0 after that edge.
- R2: A start code of 0x00 raises vblk in the cycle after the line strobe that carries the nominal start strobe. vblk changes only in the cycle after a line strobe.
- R3: Start codes 0x01 to 0x7F (bit 7 clear) raise vblk in the cycle after the line strobe that falls that many lines after the nominal start line.
- R4: Start codes 0x81 to 0xFE (bit 7 set) advance the start by the value of bits 6:0. The start fires on the line strobe at index field_lines minus that value, counting the previous nominal start line as index 0. No advanced start fires before the first nominal start strobe after reset.
- R5: Code 0xFF advances the edge by 128 lines, and code 0x80 behaves exactly like 0x00.
- R6: The end code uses the same encoding relative to the nominal end strobe and drops vblk. When an end and a start fire on the same line strobe, vblk ends up 0.
- R7: While the bypass is inactive (bypass_en low or vblk low), pix_out equals proc_in from the previous cycle, unaltered.
- R8: pix_luma is 0 in the cycle after a line strobe and toggles every cycle otherwise. A value of 0 labels the byte as colour-difference and 1 labels it as luma.
- R9: While bypass_en and vblk are both high, the next pix_out is raw_in clipped to 16..235 for a luma byte or 16..240 for a colour-difference byte (8-bit data).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_stb | input | 1 | One-cycle strobe at the start of each line |
| vb_start_nom | input | 1 | Nominal blanking start, valid with line_stb |
| vb_end_nom | input | 1 | Nominal blanking end, valid with line_stb |
| start_code | input | 8 | Signed line shift of the window start |
| end_code | input | 8 | Signed line shift of the window end |
| field_lines | input | LW | Lines between successive nominal strobes |
| bypass_en | input | 1 | Enables the raw bypass inside the window |
| raw_in | input | DW | Raw converter sample |
| proc_in | input | DW | Processed video sample |
| vblk | output | 1 | Adjusted vertical blanking flag |
| pix_out | output | DW | Selected pixel, registered |
| pix_luma | output | 1 | 1 when pix_out is a luma byte, 0 when colour-difference |

## Verification
A wrong line counter or a badly decoded shift code shows up as a vblk edge on the wrong line. That error is visible one cycle after the offending line strobe, and the bench compares vblk on every clock. A stuck or skipped phase bit flips the pix_luma label and applies the wrong clip ceiling. Both show up on the next sample once the alternation has slipped. A bypass gate that is off by one cycle shows one raw or processed byte at each window edge, and the per-clock comparison catches it immediately.

// File: rtl/vbw_pkg.sv
// Shared types and the line-shift decoder for the blanking window block.
// Assumes 8-bit shift codes; bit 7 selects direction.
package vbw_pkg;

    // Decoded shift: lead=1 means the edge moves ahead of the nominal strobe.
    typedef struct packed {
        logic       lead;
        logic [7:0] lines;
    } line_shift_t;

    // Label of the byte currently on the raw path.
    typedef enum logic {
        PH_CHROMA = 1'b0,
        PH_LUMA   = 1'b1
    } byte_phase_t;

    // Turns a shift code into direction and magnitude (0x80 -> none, 0xFF -> 128 ahead).
    function automatic line_shift_t decode_shift(input logic [7:0] code);
        line_shift_t s;
        if (!code[7]) begin
            s.lead  = 1'b0;
            s.lines = {1'b0, code[6:0]};
        end else if (code == 8'hFF) begin
            s.lead  = 1'b1;
            s.lines = 8'd128;
        end else if (code[6:0] == 7'd0) begin
            s.lead  = 1'b0;
            s.lines = 8'd0;
        end else begin
            s.lead  = 1'b1;
            s.lines = {1'b0, code[6:0]};
        end
        return s;
    endfunction

endpackage

// File: rtl/vbw_edge_locator.sv
// Finds the line on which one shifted window edge falls.
// Counts line strobes from the last nominal strobe. A delayed edge fires
// that many lines after it, and an advanced edge fires at field_lines minus
// the lead. Assumes field_lines > 128 and that nominal strobes come with line_stb.
module vbw_edge_locator
    import vbw_pkg::*;
#(
    parameter int LW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_stb,
    input  logic          nom_stb,
    input  logic [7:0]    code,
    input  logic [LW-1:0] field_lines,
    output logic          hit
);
    logic [LW-1:0] line_cnt;
    logic          ref_seen;
    line_shift_t   shift;
    logic [LW-1:0] target;
    logic [LW-1:0] line_idx;
    logic          nom_now;

    // Decode the shift and form the line index the edge must land on.
    always_comb begin
        shift    = decode_shift(code);
        nom_now  = nom_stb & line_stb;
        target   = shift.lead ? (field_lines - LW'(shift.lines)) : LW'(shift.lines);
        line_idx = nom_now ? '0 : (line_cnt + 1'b1);
        hit      = line_stb && (nom_now || ref_seen) && (line_idx == target);
    end

    // Track lines since the last nominal strobe and whether one has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt <= '0;
            ref_seen <= 1'b0;
        end else if (line_stb) begin
            line_cnt <= line_idx;
            ref_seen <= ref_seen | nom_now;
        end
    end

endmodule

// File: rtl/vbw_window.sv
// Holds the adjusted blanking flag between its start and end events.
// An end event takes priority over a start event on the same line.
module vbw_window (
    input  logic clk,
    input  logic rst_n,
    input  logic start_hit,
    input  logic end_hit,
    output logic vblk
);
    // Set on start, clear on end, with the end event taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vblk <= 1'b0;
        else if (end_hit)
            vblk <= 1'b0;
        else if (start_hit)
            vblk <= 1'b1;
    end

endmodule

// File: rtl/vbw_raw_path.sv
// Selects processed or clipped raw samples and labels each byte.
// The label alternates every cycle and restarts as colour-difference on a
// line strobe. One register stage from the inputs to pix_out.
module vbw_raw_path
    import vbw_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_stb,
    input  logic          bypass,
    input  logic [DW-1:0] raw_in,
    input  logic [DW-1:0] proc_in,
    output logic [DW-1:0] pix_out,
    output logic          pix_luma
);
    localparam int SH = DW - 8;
    localparam logic [DW-1:0] LO_LIM   = DW'(16)  << SH;
    localparam logic [DW-1:0] Y_HI     = DW'(235) << SH;
    localparam logic [DW-1:0] C_HI     = DW'(240) << SH;

    byte_phase_t   next_ph;
    byte_phase_t   cur_ph;
    logic [DW-1:0] hi_lim;
    logic [DW-1:0] clipped;

    // Work out the label of this cycle's byte and clip the raw sample to its range.
    always_comb begin
        cur_ph = line_stb ? PH_CHROMA : next_ph;
        hi_lim = (cur_ph == PH_LUMA) ? Y_HI : C_HI;
        if (raw_in < LO_LIM)
            clipped = LO_LIM;
        else if (raw_in > hi_lim)
            clipped = hi_lim;
        else
            clipped = raw_in;
    end

    // Advance the label and register the selected sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_ph  <= PH_CHROMA;
            pix_out  <= '0;
            pix_luma <= 1'b0;
        end else begin
            next_ph  <= (cur_ph == PH_LUMA) ? PH_CHROMA : PH_LUMA;
            pix_out  <= bypass ? clipped : proc_in;
            pix_luma <= (cur_ph == PH_LUMA);
        end
    end

endmodule

// File: rtl/vblank_luma_bypass.sv
// Top: adjusted vertical blanking flag plus raw luma bypass inside it.
// Two edge locators (start and end) feed the flag register, and the flag
// combined with bypass_en steers the raw path. Assumes field_lines > 128, LW >= 9.
module vblank_luma_bypass #(
    parameter int DW = 8,
    parameter int LW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_stb,
    input  logic          vb_start_nom,
    input  logic          vb_end_nom,
    input  logic [7:0]    start_code,
    input  logic [7:0]    end_code,
    input  logic [LW-1:0] field_lines,
    input  logic          bypass_en,
    input  logic [DW-1:0] raw_in,
    input  logic [DW-1:0] proc_in,
    output logic          vblk,
    output logic [DW-1:0] pix_out,
    output logic          pix_luma
);
    logic start_hit;
    logic end_hit;
    logic bypass_on;

    vbw_edge_locator #(.LW(LW)) u_start_loc (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_stb   (line_stb),
        .nom_stb    (vb_start_nom),
        .code       (start_code),
        .field_lines(field_lines),
        .hit        (start_hit)
    );

    vbw_edge_locator #(.LW(LW)) u_end_loc (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_stb   (line_stb),
        .nom_stb    (vb_end_nom),
        .code       (end_code),
        .field_lines(field_lines),
        .hit        (end_hit)
    );

    vbw_window u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_hit(start_hit),
        .end_hit  (end_hit),
        .vblk     (vblk)
    );

    // Bypass is live only inside the window and when enabled.
    always_comb bypass_on = vblk & bypass_en;

    vbw_raw_path #(.DW(DW)) u_raw (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_stb(line_stb),
        .bypass  (bypass_on),
        .raw_in  (raw_in),
        .proc_in (proc_in),
        .pix_out (pix_out),
        .pix_luma(pix_luma)
    );

endmodule

// File: rtl/vblank_luma_bypass_chk.sv
// Port-level properties of the blanking window block, bound onto the top.
module vblank_luma_bypass_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          line_stb,
    input logic          bypass_en,
    input logic [DW-1:0] proc_in,
    input logic          vblk,
    input logic [DW-1:0] pix_out,
    input logic          pix_luma
);
    localparam logic [DW-1:0] LO_LIM = DW'(16)  << (DW - 8);
    localparam logic [DW-1:0] Y_HI   = DW'(235) << (DW - 8);
    localparam logic [DW-1:0] C_HI   = DW'(240) << (DW - 8);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!vblk && pix_out == '0 && !pix_luma));

    // R2
    vblk_on_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(vblk)) |-> $past(line_stb));

    // R7
    passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bypass_en && vblk)) |-> (pix_out == $past(proc_in)));

    // R8
    phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(line_stb)) |-> !pix_luma);

    // R8
    phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && !$past(line_stb)) |-> (pix_luma != $past(pix_luma)));

    // R9
    clip_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bypass_en && vblk)) |->
        (pix_out >= LO_LIM && pix_out <= (pix_luma ? Y_HI : C_HI)));

endmodule

bind vblank_luma_bypass vblank_luma_bypass_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_stb (line_stb),
    .bypass_en(bypass_en),
    .proc_in  (proc_in),
    .vblk     (vblk),
    .pix_out  (pix_out),
    .pix_luma (pix_luma)
);

// File: tb/test_vblank_luma_bypass.sv
module test_vblank_luma_bypass;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int LW = 10;
    localparam int FIELD = 150;
    localparam int LINE_LEN = 8;
    localparam int END_IDX = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_stb = 1'b0;
    logic          vb_start_nom = 1'b0;
    logic          vb_end_nom = 1'b0;
    logic [7:0]    start_code = 8'h00;
    logic [7:0]    end_code = 8'h00;
    logic [LW-1:0] field_lines = LW'(FIELD);
    logic          bypass_en = 1'b0;
    logic [DW-1:0] raw_in = '0;
    logic [DW-1:0] proc_in = '0;
    logic          vblk;
    logic [DW-1:0] pix_out;
    logic          pix_luma;

    vblank_luma_bypass #(.DW(DW), .LW(LW)) i_vblank_luma_bypass (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb),
        .vb_start_nom(vb_start_nom), .vb_end_nom(vb_end_nom),
        .start_code(start_code), .end_code(end_code), .field_lines(field_lines),
        .bypass_en(bypass_en), .raw_in(raw_in), .proc_in(proc_in),
        .vblk(vblk), .pix_out(pix_out), .pix_luma(pix_luma)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    finished = 0;

    // Reference model state
    int    abs_line = -1;
    int    last_s = 0, last_e = 0;
    bit    seen_s = 0, seen_e = 0;
    bit    m_vblk = 0;
    bit    m_next_luma = 0;
    int    e_pix = 0;
    bit    e_luma = 0;
    bit    e_vblk = 0;
    string pix_tag = "R1";
    string win_tag = "R1";

    // Signed shift in lines: positive = later, negative = earlier.
    function automatic int shift_of(input int code);
        if (code < 128)  return code;
        if (code == 255) return -128;
        if (code == 128) return 0;
        return -(code - 128);
    endfunction

    function automatic bit edge_here(input int code, input int last, input bit seen, input int n);
        int sh = shift_of(code);
        if (!seen) return 0;
        if (sh >= 0) return n == last + sh;
        return n == last + FIELD + sh;
    endfunction

    function automatic int clip(input int v, input bit luma);
        int hi = luma ? 235 : 240;
        if (v < 16) return 16;
        if (v > hi) return hi;
        return v;
    endfunction

    // Predict the outputs after the coming clock edge from the driven inputs.
    task automatic model_step();
        bit luma_now;
        bit fs, fe;
        luma_now = line_stb ? 1'b0 : m_next_luma;
        if (m_vblk && bypass_en) begin
            e_pix = clip(int'(raw_in), luma_now);
            pix_tag = "R9";
        end else begin
            e_pix = int'(proc_in);
            pix_tag = "R7";
        end
        e_luma = luma_now;
        m_next_luma = !luma_now;
        if (line_stb) begin
            abs_line++;
            if (vb_start_nom) begin last_s = abs_line; seen_s = 1; end
            if (vb_end_nom)   begin last_e = abs_line; seen_e = 1; end
            fs = edge_here(int'(start_code), last_s, seen_s, abs_line);
            fe = edge_here(int'(end_code), last_e, seen_e, abs_line);
            if (fe) m_vblk = 0;
            else if (fs) m_vblk = 1;
        end
        e_vblk = m_vblk;
    endtask

    task automatic compare();
        n_vec++;
        if (vblk !== e_vblk) begin
            n_bad++;
            $display("FAIL %s vblk actual=%0b expected=%0b at %0t", win_tag, vblk, e_vblk, $time);
        end else if (pix_out !== DW'(e_pix)) begin
            n_bad++;
            $display("FAIL %s pix_out actual=%0d expected=%0d at %0t", pix_tag, pix_out, e_pix, $time);
        end else if (pix_luma !== e_luma) begin
            n_bad++;
            $display("FAIL R8 pix_luma actual=%0b expected=%0b at %0t", pix_luma, e_luma, $time);
        end
    endtask

    // One field: nominal start on line 0, nominal end on line END_IDX.
    task automatic run_field(input logic [7:0] sc, input logic [7:0] ec, input bit byp, input string tag);
        start_code = sc;
        end_code = ec;
        bypass_en = byp;
        win_tag = tag;
        for (int ln = 0; ln < FIELD; ln++) begin
            for (int c = 0; c < LINE_LEN; c++) begin
                @(negedge clk);
                compare();
                line_stb = (c == 0);
                vb_start_nom = (c == 0) && (ln == 0);
                vb_end_nom = (c == 0) && (ln == END_IDX);
                raw_in = DW'($urandom);
                proc_in = DW'($urandom);
                model_step();
            end
        end
    endtask

    initial begin
        // R1: outputs cleared while reset is held
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            raw_in = DW'($urandom);
            proc_in = DW'($urandom);
            line_stb = (i == 1);
            if (i > 0) compare();
        end
        rst_n = 1'b1;
        line_stb = 1'b0;
        m_next_luma = 0;
        model_step();
        run_field(8'h00, 8'h00, 1, "R2");
        run_field(8'h05, 8'h03, 1, "R3");
        run_field(8'h81, 8'h00, 1, "R4");
        run_field(8'hFF, 8'h85, 1, "R5");
        run_field(8'h80, 8'h7F, 1, "R5");
        run_field(8'h14, 8'h00, 1, "R6");
        run_field(8'h00, 8'h02, 0, "R7");
        run_field(8'h90, 8'h00, 1, "R4");
        @(negedge clk);
        compare();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule